// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences external bus cycles for two memory areas. A request is taken when the bus is idle. Each request selects an area, a direction and, optionally, a burst length. The block steps through a start state, a run of wait states and a data state. It drives chip select and the read or write strobe through the whole access, and it pulses a ready output once per data beat.

Each area has its own 3-bit wait code in a 16-bit configuration register. The code sets the number of wait states in the first beat of an access. It also sets the length of each later beat in a burst. The two counts are not a linear function of each other. An external wait input stretches a beat by one state for every sampled cycle in which it is high. At code 000 the wait input is ignored in the first beat but still honoured in burst beats.

The current bus state is brought out so that surrounding logic can follow the cycle.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset the block is idle (state 0), with cs_o, rd_o, wr_o and ready_o low. Both wait codes reset to 111, so the first access to either area gets 10 wait states.
- R2: The area 1 code is held in cfg_wdata_i bits 15:13 and the area 0 code in bits 12:10. Writing one field leaves the other area's timing unchanged. area_sel_i picks the field used by an access.
- R3: Without wait input, the first beat of an access ends with ready in its cycle W+2, counting the start state as cycle 1. W is 0, 1, 2, 3, 4, 6, 8 or 10 for codes 000 through 111.
- R4: Each burst beat after the first lasts N cycles, ending with its ready cycle, when the wait input is low. N is 2, 2, 3, 4, 4, 6, 8 or 10 for codes 000 through 111.
- R5: With code 000 the wait input has no effect on the first beat. Ready is always in cycle 2.
- R6: With a nonzero code, wait_i is sampled from the last programmed wait state onward. Each sampled cycle with wait_i high adds one wait state. A high level before the last programmed wait state adds nothing.
- R7: In burst beats wait_i is sampled from the beat's last state before its data state onward, for every code including 000. Each sampled high cycle adds one state.
- R8: cs_o is high from the start state through the final data state and low otherwise. rd_o equals cs_o for a read (rw_i=0) and wr_o equals cs_o for a write (rw_i=1); the two strobes are never high together.
- R9: ready_o is high for exactly one clock per beat. With burst_i=1 the access has beats_i+1 beats. With burst_i=0 it has one beat whatever beats_i holds.
- R10: A configuration write made during an access, or on the same clock edge that accepts a request, affects only later accesses.
- R11: A request held high is accepted in the idle clock that follows the final data beat. The start state appears on the next clock.
- R12: state_o encodes the bus state: 0 idle, 1 start, 2 first-beat wait, 3 data/ready, 4 burst-beat state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request, sampled while idle |
| area_sel_i | input | 1 | Area of the request (0 or 1) |
| rw_i | input | 1 | Direction: 0 read, 1 write |
| burst_i | input | 1 | Request is a burst |
| beats_i | input | 3 | Burst beats after the first |
| wait_i | input | 1 | External wait, active high |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 16 | Configuration register write data |
| cs_o | output | 1 | Chip select, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| ready_o | output | 1 | One-clock pulse per completed beat |
| state_o | output | 3 | Current bus state code |

## Verification
A wrong wait count or a wrong wait code shows as ready_o arriving early or late. The shift appears within the beat it affects, so the bench compares the exact cycle of every ready pulse and the full state_o trace against counts computed from the code tables. A counter that fails to hold while wait_i is high shortens the beat at once. A sequencer that leaks a configuration write into a running access moves that access's ready pulse. A stuck or leaking strobe is caught in the cycle after the final beat, where cs_o and state_o must have returned to idle.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DATA  = 3'd3,
    ST_BEAT  = 3'd4
  } bus_state_e;

endpackage

// File: rtl/bwc_rst_sync.sv
module bwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg #(
  parameter int REG_W    = 16,
  parameter int FIELD_W  = 3,
  parameter int N_AREA   = 2,
  parameter int BASE_LSB = 10,
  localparam int AREA_W  = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we_i,
  input  logic [REG_W-1:0]   cfg_wdata_i,
  input  logic [AREA_W-1:0]  area_sel_i,
  output logic [FIELD_W-1:0] code_o
);

  logic [N_AREA-1:0][FIELD_W-1:0] field_q;

  // one field per area, stacked upward from BASE_LSB
  generate
    for (genvar a = 0; a < N_AREA; a++) begin : g_area
      localparam int LSB = BASE_LSB + a * FIELD_W;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          field_q[a] <= '1;
        end else if (cfg_we_i) begin
          field_q[a] <= cfg_wdata_i[LSB +: FIELD_W];
        end
      end
    end
  endgenerate

  assign code_o = field_q[area_sel_i];

endmodule

// File: rtl/bwc_code_dec.sv
module bwc_code_dec #(
  parameter int FIELD_W = 3,
  parameter int CNT_W   = 4
) (
  input  logic [FIELD_W-1:0] code_i,
  output logic [CNT_W-1:0]   first_w_o,
  output logic [CNT_W-1:0]   beat_n_o
);

  logic [CNT_W-1:0] code_ext;

  assign code_ext = CNT_W'(code_i);

  always_comb begin
    // first-beat waits: linear up to 4, then step of two
    if (code_ext <= CNT_W'(4)) begin
      first_w_o = code_ext;
    end else begin
      first_w_o = (code_ext << 1) - CNT_W'(4);
    end
    // burst beat length: floor of 2, one above the code in the middle,
    // equal to the first-beat waits from code 4 upward
    if (code_ext == '0) begin
      beat_n_o = CNT_W'(2);
    end else if (code_ext < CNT_W'(4)) begin
      beat_n_o = code_ext + CNT_W'(1);
    end else begin
      beat_n_o = first_w_o;
    end
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rw_i,
  input  logic              burst_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              wait_i,
  input  logic [CNT_W-1:0]  first_w_i,
  input  logic [CNT_W-1:0]  beat_n_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ready_o,
  output logic [2:0]        state_o
);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic [CNT_W-1:0]  w_q, n_q;
  logic              rw_q;
  logic              acc_load;
  logic              cnt_last;

  assign acc_load = (state_q == ST_IDLE) && req_i;
  assign cnt_last = (cnt_q <= CNT_W'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_START;
          left_d  = burst_i ? beats_i : '0;
        end
      end
      ST_START: begin
        if (w_q == '0) begin
          state_d = ST_DATA;
        end else begin
          state_d = ST_WAIT;
          cnt_d   = w_q;
        end
      end
      ST_WAIT, ST_BEAT: begin
        if (!cnt_last) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!wait_i) begin
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (left_q != '0) begin
          state_d = ST_BEAT;
          cnt_d   = n_q - CNT_W'(1);
          left_d  = left_q - BEAT_W'(1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
    end
  end

  // access attributes captured once, at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      n_q  <= '0;
      rw_q <= 1'b0;
    end else if (acc_load) begin
      w_q  <= first_w_i;
      n_q  <= beat_n_i;
      rw_q <= rw_i;
    end
  end

  assign cs_o    = (state_q != ST_IDLE);
  assign rd_o    = cs_o && !rw_q;
  assign wr_o    = cs_o && rw_q;
  assign ready_o = (state_q == ST_DATA);
  assign state_o = state_q;

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl #(
  parameter int REG_W    = 16,
  parameter int FIELD_W  = 3,
  parameter int N_AREA   = 2,
  parameter int BASE_LSB = 10,
  parameter int CNT_W    = 4,
  parameter int BEAT_W   = 3,
  parameter int SYNC_STG = 2,
  localparam int AREA_W  = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_i,
  input  logic [AREA_W-1:0] area_sel_i,
  input  logic              rw_i,
  input  logic              burst_i,
  input  logic [BEAT_W-1:0] beats_i,
  input  logic              wait_i,
  input  logic              cfg_we_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ready_o,
  output logic [2:0]        state_o
);

  logic               rst_n;
  logic [FIELD_W-1:0] sel_code;
  logic [CNT_W-1:0]   first_w;
  logic [CNT_W-1:0]   beat_n;

  bwc_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n_o(rst_n)
  );

  bwc_cfg_reg #(
    .REG_W   (REG_W),
    .FIELD_W (FIELD_W),
    .N_AREA  (N_AREA),
    .BASE_LSB(BASE_LSB)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i),
    .area_sel_i (area_sel_i),
    .code_o     (sel_code)
  );

  bwc_code_dec #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec (
    .code_i   (sel_code),
    .first_w_o(first_w),
    .beat_n_o (beat_n)
  );

  bwc_seq #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .rw_i     (rw_i),
    .burst_i  (burst_i),
    .beats_i  (beats_i),
    .wait_i   (wait_i),
    .first_w_i(first_w),
    .beat_n_i (beat_n),
    .cs_o     (cs_o),
    .rd_o     (rd_o),
    .wr_o     (wr_o),
    .ready_o  (ready_o),
    .state_o  (state_o)
  );

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       wait_i,
  input logic       cs_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       ready_o,
  input logic [2:0] state_o
);

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  p_ready_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> cs_o);

  p_cs_rise_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (state_o == 3'd1));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));

  p_accept_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && req_i) |=> (state_o == 3'd1));

  p_start_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |=> (state_o == 3'd2 || state_o == 3'd3));

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && wait_i) |=> (state_o == 3'd2));

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && wait_i) |=> (state_o == 3'd4));

endmodule

bind bus_wait_ctrl bwc_checker u_bwc_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .wait_i (wait_i),
  .cs_o   (cs_o),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .ready_o(ready_o),
  .state_o(state_o)
);

// File: tb/test_bus_wait_ctrl.sv
module test_bus_wait_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 64;

  logic        clk;
  logic        arst_n;
  logic        req_i;
  logic [0:0]  area_sel_i;
  logic        rw_i;
  logic        burst_i;
  logic [2:0]  beats_i;
  logic        wait_i;
  logic        cfg_we_i;
  logic [15:0] cfg_wdata_i;
  logic        cs_o, rd_o, wr_o, ready_o;
  logic [2:0]  state_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int code_sh [2];
  int fw_tab [8] = '{0, 1, 2, 3, 4, 6, 8, 10};
  int bn_tab [8] = '{2, 2, 3, 4, 4, 6, 8, 10};

  bus_wait_ctrl i_bus_wait_ctrl (
    .clk(clk), .arst_n(arst_n), .req_i(req_i), .area_sel_i(area_sel_i),
    .rw_i(rw_i), .burst_i(burst_i), .beats_i(beats_i), .wait_i(wait_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cs_o(cs_o), .rd_o(rd_o),
    .wr_o(wr_o), .ready_o(ready_o), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic write_cfg(input int c1, input int c0);
    cfg_wdata_i = 16'((c1 << 13) | (c0 << 10));
    cfg_we_i = 1'b1;
    @(negedge clk);
    cfg_we_i = 1'b0;
    code_sh[1] = c1;
    code_sh[0] = c0;
  endtask

  // one access; expected per-cycle state built from the code tables
  task automatic run_access(input int area, input int rw, input int burst,
                            input int beats, input int ws, input int we,
                            input int wr_rel, input int wr_c1, input int wr_c0,
                            input bit hold, input string tag);
    int st [MAXR];
    int w, n, nb, c, t2, s, last;
    int bad_t, bad_s, bad_x, a_t, e_t, a_s, e_s;
    w  = fw_tab[code_sh[area]];
    n  = bn_tab[code_sh[area]];
    nb = burst ? beats + 1 : 1;
    for (int i = 0; i < MAXR; i++) st[i] = 0;
    st[1] = 1;
    if (w == 0) begin
      t2 = 2;
    end else begin
      c = w + 1;
      while (c >= ws && c <= we) c++;
      for (int k = 2; k <= c; k++) st[k] = 2;
      t2 = c + 1;
    end
    st[t2] = 3;
    for (int b = 1; b < nb; b++) begin
      s = t2 + 1;
      c = s + n - 2;
      while (c >= ws && c <= we) c++;
      for (int k = s; k <= c; k++) st[k] = 4;
      t2 = c + 1;
      st[t2] = 3;
    end
    last = t2;
    bad_t = 0; bad_s = 0; bad_x = 0;
    a_t = 0; e_t = 0; a_s = 0; e_s = 0;
    req_i = 1'b1; area_sel_i = 1'(area); rw_i = 1'(rw);
    burst_i = 1'(burst); beats_i = 3'(beats); wait_i = 1'b0;
    cfg_wdata_i = 16'((wr_c1 << 13) | (wr_c0 << 10));
    cfg_we_i = (wr_rel == 0);
    @(negedge clk);
    if (!hold) req_i = 1'b0;
    for (int rel = 1; rel <= last + 1; rel++) begin
      wait_i = (rel >= ws && rel <= we);
      cfg_we_i = (rel == wr_rel);
      if (ready_o !== (st[rel] == 3) && !bad_t) begin
        bad_t = 1; a_t = rel * 10 + int'(ready_o); e_t = rel * 10 + int'(st[rel] == 3);
      end
      if (int'(state_o) != st[rel] && !bad_s) begin
        bad_s = 1; a_s = rel * 10 + int'(state_o); e_s = rel * 10 + st[rel];
      end
      if (cs_o !== (st[rel] != 0) || rd_o !== (st[rel] != 0 && rw == 0) ||
          wr_o !== (st[rel] != 0 && rw == 1))
        bad_x = bad_x + 1;
      @(negedge clk);
    end
    wait_i = 1'b0;
    cfg_we_i = 1'b0;
    if (wr_rel >= 0) begin
      code_sh[1] = wr_c1;
      code_sh[0] = wr_c0;
    end
    check(!bad_t, tag, "ready timing (rel*10+ready)", a_t, e_t);
    check(!bad_s, "R12", "state trace (rel*10+state)", a_s, e_s);
    check(bad_x == 0, "R8", "strobe mismatching cycles", bad_x, 0);
    if (hold) begin
      // now in the cycle after the idle one
      check(state_o == 3'd1, "R11", "state after held request", int'(state_o), 1);
      req_i = 1'b0;
      for (int k = 0; k < 200 && state_o != 3'd0; k++) @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    arst_n = 1'b0; req_i = 1'b0; area_sel_i = '0; rw_i = 1'b0;
    burst_i = 1'b0; beats_i = '0; wait_i = 1'b0; cfg_we_i = 1'b0;
    cfg_wdata_i = '0;
    code_sh[0] = 7; code_sh[1] = 7;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs, then default codes give 10 waits on both areas
    check(state_o == 3'd0, "R1", "reset state", int'(state_o), 0);
    check({cs_o, rd_o, wr_o, ready_o} == 4'b0, "R1", "reset strobes",
          int'({cs_o, rd_o, wr_o, ready_o}), 0);
    run_access(0, 0, 0, 0, 0, -1, -1, 0, 0, 0, "R1");
    run_access(1, 1, 0, 0, 0, -1, -1, 0, 0, 0, "R1");

    // R2/R3/R4: sweep every code on each area, opposite code on the other
    for (int area = 0; area < 2; area++) begin
      for (int code = 0; code < 8; code++) begin
        if (area == 1) write_cfg(code, 7 - code);
        else           write_cfg(7 - code, code);
        run_access(area, 0, 0, 0, 0, -1, -1, 0, 0, 0, "R3");
        run_access(area, 1, 1, 2, 0, -1, -1, 0, 0, 0, "R4");
        run_access(1 - area, 0, 1, 1, 0, -1, -1, 0, 0, 0, "R2");
      end
    end

    // R9: beats_i ignored without burst; long burst
    write_cfg(3, 2);
    run_access(0, 0, 0, 5, 0, -1, -1, 0, 0, 0, "R9");
    run_access(1, 1, 1, 3, 0, -1, -1, 0, 0, 0, "R9");

    // R5: code 000 ignores wait in the first beat
    write_cfg(0, 0);
    run_access(0, 0, 0, 0, 1, 6, -1, 0, 0, 0, "R5");
    // R7: code 000 honours wait in burst beats
    run_access(1, 0, 1, 2, 3, 5, -1, 0, 0, 0, "R7");

    // R6: extension on the last programmed wait, none before it
    for (int code = 1; code < 8; code++) begin
      write_cfg(0, code);
      run_access(0, 1, 0, 0, 1, fw_tab[code] + 3, -1, 0, 0, 0, "R6");
      run_access(0, 0, 0, 0, 1, fw_tab[code], -1, 0, 0, 0, "R6");
      run_access(0, 0, 1, 1, fw_tab[code] + 3, fw_tab[code] + 6, -1, 0, 0, 0, "R7");
    end

    // R10: writes during and at acceptance apply from the next access
    write_cfg(0, 2);
    run_access(0, 0, 1, 1, 0, -1, 2, 0, 5, 0, "R10");
    run_access(0, 0, 1, 1, 0, -1, -1, 0, 0, 0, "R10");
    run_access(0, 1, 0, 0, 0, -1, 0, 0, 1, 0, "R10");
    run_access(0, 1, 0, 0, 0, -1, -1, 0, 0, 0, "R10");

    // R11: request held across the access is taken after the idle cycle
    write_cfg(0, 0);
    run_access(0, 0, 0, 0, 0, -1, -1, 0, 0, 1, "R11");
    write_cfg(4, 1);
    run_access(1, 1, 1, 1, 0, -1, -1, 0, 0, 1, "R11");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule